// File: doc/BRIEF.md
# I2C Serial EEPROM Write Front-End

This block is the target-side protocol decoder for a serial EEPROM of 128K bytes. It watches SCL and SDA, which reach it already sampled by the system clock. It recognises START, repeated START and STOP, and it matches the target address byte against a fixed 4-bit device code and two chip-select pins. It then collects a two-byte word address and the data bytes that follow. It acknowledges by pulling SDA low during the acknowledge clock.

Every data byte it accepts is handed to a page-write engine. The handoff carries the page number (address bit 16 from the target address byte, joined with the high address byte), the byte offset inside the page and the data. On the STOP that ends a write with at least one accepted data byte, the block pulses a start request to the engine.

While the engine reports busy, the block refuses its target address, so a host can poll with a read-type request until the device answers again. A write-protect pin can reject a whole write at its first data byte. The read datapath, clock stretching and analog timing are not part of this block.

Top module: `eeprom_wr_front`

## Requirements
- R1: A target address byte is accepted only when bits 7:4 equal 4'b1010 and bits 3:2 equal `chip_sel`. Otherwise it gets no acknowledge, and no later byte of that transaction is acknowledged, loaded or committed.
- R2: Bit 1 of the target address byte is word address bit 16, and bit 0 is the direction (1 = read). `page` = {bit 16, first address byte} and the first `offset` = second address byte. Each accepted data byte gives one single-cycle `load` pulse with its `offset` and `data`. The offset then increments and wraps from 8'hFF to 8'h00 inside the same page.
- R3: In a write, the target address byte, both address bytes and every data byte are acknowledged.
- R4: A STOP that follows at least one accepted data byte of a write gives one `commit` pulse, with `page` holding that write's page.
- R5: A STOP that comes before any data byte has been accepted gives no `commit`.
- R6: While `engine_busy` is high when a target address byte completes, that byte is not acknowledged, whether it requests a read or a write.
- R7: When not busy, a matching target address byte with the read bit set is acknowledged (used for acknowledge polling), and nothing after it is acknowledged, loaded or committed.
- R8: `wp` is sampled only on the SCL falling edge that ends the acknowledge of the second address byte. If it is high there, the first data byte is not acknowledged, no `load` occurs and no `commit` follows. A level of `wp` at other times has no effect.
- R9: With `wp` low, writes complete normally.
- R10: A repeated START aborts the transaction in progress, so the aborted write is never committed, and the block decodes a new target address byte.
- R11: `sda_pull` changes only one clock after an SCL falling edge, so the block never moves SDA while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl | input | 1 | Sampled serial clock |
| sda | input | 1 | Sampled serial data (wired bus level) |
| wp | input | 1 | Write-protect level |
| chip_sel | input | 2 | Device-select strap compared with address byte bits 3:2 |
| engine_busy | input | 1 | Page-write engine is running an internal write |
| sda_pull | output | 1 | 1 = pull SDA low (acknowledge) |
| page | output | 9 | Page number of the current write |
| offset | output | 8 | Byte offset of the loaded data byte |
| data | output | 8 | Loaded data byte |
| load | output | 1 | One-cycle strobe: offset/data valid |
| commit | output | 1 | One-cycle strobe: start the internal write |

## Verification
Some properties are checked on every cycle: the acknowledge drive moves only after an SCL fall, a busy engine never sees an acknowledge of the target address, a write blocked by the protect pin produces no acknowledge or load, and a commit follows a STOP condition on the bus. Other behaviour depends on the whole transaction, and only the bench scenarios can show it. This covers address matching against the select straps, page and offset assembly with wrap-around, the exact edge at which the protect pin is strobed, the polling sequence and the abort by repeated START.

// File: rtl/eeprom_wr_front.sv
module eeprom_wr_front #(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl,
  input  logic       sda,
  input  logic       wp,
  input  logic [1:0] chip_sel,
  input  logic       engine_busy,
  output logic       sda_pull,
  output logic [8:0] page,
  output logic [7:0] offset,
  output logic [7:0] data,
  output logic       load,
  output logic       commit
);
  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_DATA, S_SKIP} st_t;

  st_t        state;
  logic       scl_r, sda_r, in_ack, a16, wp_lat, have_data;
  logic [3:0] bitcnt;
  logic [7:0] shreg, ahi, ptr;

  wire scl_rise  = scl & ~scl_r;
  wire scl_fall  = ~scl & scl_r;
  wire start_c   = scl & scl_r & sda_r & ~sda;
  wire stop_c    = scl & scl_r & ~sda_r & sda;
  wire byte_done = scl_fall && !in_ack && bitcnt == 4'd8;
  wire dev_match = shreg[7:4] == DEV_CODE && shreg[3:2] == chip_sel && !engine_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; scl_r <= 1'b1; sda_r <= 1'b1; in_ack <= 1'b0;
      bitcnt <= '0; shreg <= '0; ahi <= '0; ptr <= '0; a16 <= 1'b0;
      wp_lat <= 1'b0; have_data <= 1'b0; sda_pull <= 1'b0;
      page <= '0; offset <= '0; data <= '0; load <= 1'b0; commit <= 1'b0;
    end else begin
      scl_r  <= scl;
      sda_r  <= sda;
      load   <= 1'b0;
      commit <= 1'b0;
      if (start_c) begin
        state <= S_DEV; bitcnt <= '0; in_ack <= 1'b0; sda_pull <= 1'b0;
        have_data <= 1'b0; wp_lat <= 1'b0;
      end else if (stop_c) begin
        commit <= have_data && state == S_DATA;
        state <= S_IDLE; in_ack <= 1'b0; sda_pull <= 1'b0; have_data <= 1'b0;
      end else if (state != S_IDLE) begin
        if (scl_rise && !in_ack && bitcnt != 4'd8) begin
          shreg  <= {shreg[6:0], sda};
          bitcnt <= bitcnt + 4'd1;
        end
        if (byte_done) begin
          in_ack <= 1'b1;
          case (state)
            S_DEV: begin
              if (dev_match) begin
                sda_pull <= 1'b1;
                if (shreg[0]) state <= S_SKIP;
                else begin a16 <= shreg[1]; state <= S_AHI; end
              end else state <= S_SKIP;
            end
            S_AHI: begin sda_pull <= 1'b1; ahi <= shreg; state <= S_ALO; end
            S_ALO: begin
              sda_pull <= 1'b1; ptr <= shreg; page <= {a16, ahi}; state <= S_DATA;
            end
            S_DATA: begin
              if (!have_data && wp_lat) state <= S_SKIP;
              else begin
                sda_pull <= 1'b1; data <= shreg; offset <= ptr;
                ptr <= ptr + 8'd1; load <= 1'b1; have_data <= 1'b1;
              end
            end
            default: sda_pull <= 1'b0;
          endcase
        end else if (scl_fall && in_ack) begin
          in_ack <= 1'b0; sda_pull <= 1'b0; bitcnt <= '0;
          if (state == S_DATA && !have_data) wp_lat <= wp;
        end
      end
    end
  end
endmodule

module eeprom_wr_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl,
  input logic       sda,
  input logic       sda_pull,
  input logic       load,
  input logic       commit,
  input logic       engine_busy,
  input logic       byte_done,
  input logic [2:0] st,
  input logic       have_data,
  input logic       wp_lat
);
  localparam logic [2:0] ST_DEV = 3'd1, ST_DATA = 3'd4;

  assert_pull_rise_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !$past(scl) && $past(scl, 2));
  assert_pull_fall_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> (!$past(scl) && $past(scl, 2)) || ($past(scl) && !$past(sda)));
  assert_busy_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st == ST_DEV && engine_busy) |=> !sda_pull);
  assert_wp_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st == ST_DATA && !have_data && wp_lat) |=> !sda_pull && !load);
  assert_commit_on_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(scl) && $past(sda) && !$past(sda, 2));
  assert_load_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load);
  assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load, commit}));
endmodule

bind eeprom_wr_front eeprom_wr_front_chk chk (
  .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda), .sda_pull(sda_pull),
  .load(load), .commit(commit), .engine_busy(engine_busy), .byte_done(byte_done),
  .st(state), .have_data(have_data), .wp_lat(wp_lat)
);

// File: tb/eeprom_wr_front_test.sv
module eeprom_wr_front_test;
  localparam int Q = 4;
  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1, wp = 0, engine_busy = 0;
  logic [1:0] chip_sel = 2'b00;
  logic sda_pull, load, commit;
  logic [8:0] page;
  logic [7:0] offset, data;
  wire sda_bus = sda_m & ~sda_pull;

  eeprom_wr_front uut (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda_bus), .wp(wp), .chip_sel(chip_sel),
    .engine_busy(engine_busy), .sda_pull(sda_pull), .page(page), .offset(offset),
    .data(data), .load(load), .commit(commit)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, n_load = 0, n_commit = 0;
  logic [7:0] offs [0:7];
  logic [7:0] last_data;
  logic [8:0] last_page;
  bit done = 0;

  always @(negedge clk) begin
    if (load) begin
      if (n_load < 8) offs[n_load] = offset;
      last_data = data;
      n_load++;
    end
    if (commit) begin last_page = page; n_commit++; end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask
  task automatic clr(); n_load = 0; n_commit = 0; endtask

  task automatic start_c();
    sda_m = 1; w(Q); scl = 1; w(Q); sda_m = 0; w(Q); scl = 0; w(Q);
  endtask
  task automatic stop_c();
    sda_m = 0; w(Q); scl = 1; w(Q); sda_m = 1; w(2 * Q);
  endtask
  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(Q); scl = 1; w(2 * Q); scl = 0; w(Q);
    end
    sda_m = 1; w(Q); scl = 1; w(Q); ack = ~sda_bus; w(Q); scl = 0; w(Q);
  endtask

  localparam int NV = 6;
  localparam logic [37:0] VEC [NV] = '{
    {8'hA0, 8'h12, 8'h34, 8'h5A, 1'b0, 4'b1111, 1'b1},
    {8'hA2, 8'hFF, 8'h10, 8'hC3, 1'b0, 4'b1111, 1'b1},
    {8'hA4, 8'h00, 8'h00, 8'h11, 1'b0, 4'b0000, 1'b0},
    {8'hB0, 8'h00, 8'h00, 8'h22, 1'b0, 4'b0000, 1'b0},
    {8'hA0, 8'h00, 8'h00, 8'h77, 1'b1, 4'b1110, 1'b0},
    {8'hA1, 8'h00, 8'h00, 8'h00, 1'b0, 4'b1000, 1'b0}
  };

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2, a3;
    logic [7:0] dv, hi, lo, dt;
    w(5); rst_n = 1; w(4);
    chk("R11 reset sda_pull", sda_pull, 0);
    chk("R4 reset commit count", n_commit, 0);
    chk("R2 reset load count", n_load, 0);

    for (int v = 0; v < NV; v++) begin
      {dv, hi, lo, dt} = VEC[v][37:6];
      wp = VEC[v][5];
      clr();
      start_c(); send(dv, a0); send(hi, a1); send(lo, a2); send(dt, a3); stop_c(); w(4);
      chk($sformatf("R1 R3 R7 R8 vec%0d acks", v), {a0, a1, a2, a3}, VEC[v][4:1]);
      chk($sformatf("R2 R9 vec%0d loads", v), n_load, VEC[v][1]);
      chk($sformatf("R4 vec%0d commits", v), n_commit, VEC[v][0]);
      if (VEC[v][0]) begin
        chk($sformatf("R2 vec%0d page", v), last_page, {dv[1], hi});
        chk($sformatf("R2 vec%0d offset", v), offs[0], lo);
        chk($sformatf("R2 vec%0d data", v), last_data, dt);
      end
      wp = 0;
    end

    engine_busy = 1; clr();
    start_c(); send(8'hA0, a0); stop_c();
    chk("R6 busy write address nack", a0, 0);
    start_c(); send(8'hA1, a0); stop_c();
    chk("R6 busy poll nack", a0, 0);
    engine_busy = 0;
    start_c(); send(8'hA1, a0); stop_c();
    chk("R7 poll ack when idle", a0, 1);
    chk("R6 no commit while busy", n_commit, 0);

    clr();
    start_c(); send(8'hA0, a0); send(8'h05, a1); send(8'hFE, a2);
    send(8'h01, a3); send(8'h02, a3); send(8'h03, a3); stop_c(); w(4);
    chk("R2 wrap load count", n_load, 3);
    chk("R2 wrap offset0", offs[0], 8'hFE);
    chk("R2 wrap offset1", offs[1], 8'hFF);
    chk("R2 wrap offset2", offs[2], 8'h00);
    chk("R2 wrap last data", last_data, 8'h03);
    chk("R4 wrap page", last_page, 9'h005);

    clr();
    start_c(); send(8'hA0, a0); send(8'h12, a1); send(8'h34, a2); stop_c(); w(4);
    chk("R3 address-only acks", {a0, a1, a2}, 3'b111);
    chk("R5 no commit without data", n_commit, 0);

    clr();
    start_c(); send(8'hA0, a0); send(8'h12, a1); send(8'h34, a2); send(8'h55, a3);
    start_c(); send(8'hA2, a0); send(8'h01, a1); send(8'h02, a2); send(8'h66, a3);
    stop_c(); w(4);
    chk("R10 second transaction ack", {a0, a3}, 2'b11);
    chk("R10 single commit", n_commit, 1);
    chk("R10 committed page", last_page, 9'h101);
    chk("R10 last data", last_data, 8'h66);

    clr();
    wp = 1; start_c(); send(8'hA0, a0); send(8'h00, a1);
    wp = 0; send(8'h08, a2); send(8'h99, a3); stop_c(); w(4);
    chk("R8 wp high early ignored", a3, 1);
    chk("R8 wp early commit", n_commit, 1);
    clr();
    start_c(); send(8'hA0, a0); send(8'h00, a1); send(8'h09, a2);
    wp = 1; send(8'h98, a3); stop_c(); w(4);
    wp = 0;
    chk("R8 wp high late ignored", a3, 1);
    chk("R8 wp late commit", n_commit, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule